// File: doc/BRIEF.md
# Flash Bus Command Sequence Decoder

This block sits on the host side of a byte-wide flash array. It watches the host's write cycles and turns the multi-write unlock sequences into one-cycle request pulses for the embedded erase/program engine. A write occurs while both active-low chip enable and write enable are low. The strobe is the OR of the two. It passes through a synchronizer to the system clock and is then split into a falling-edge event and a rising-edge event. The falling edge captures the address. The rising edge samples the data and moves the sequence state machine.

Erase commands take six writes: two unlock writes, an erase setup, two more unlock writes, and the final code. A program takes three writes (two unlock writes and a program setup) and then one write that carries the target address and byte. Suspend and resume are single writes. Whether they are accepted depends on status inputs driven by the engine. Any write that does not fit the expected step returns the decoder to read mode. A reset code written at any point does the same.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, every request output is low and the decoder is in read mode.
- R2: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h produce exactly one chip-erase pulse, one clock long. No other request is raised. The address compare uses the low 11 address bits.
- R3: The same five-write prefix, followed by 30h at any address, produces one sector-erase pulse. The sector output equals the top 3 address bits of that last write.
- R4: The writes AAh@555h, 55h@2AAh, A0h@555h, then one more write produce one program pulse. That pulse carries the fourth write's address and data.
- R5: A write that does not match the expected step returns the decoder to read mode. A later command code on its own then raises nothing.
- R6: A write of F0h returns the decoder to read mode from any step, including the step that waits for program data. It raises no request.
- R7: The address of a write is the one present when the strobe falls. The data is the one present when the strobe rises.
- R8: A write takes effect only while both enables are low. A pulse on write enable alone is ignored.
- R9: B0h in read mode raises a suspend pulse only while the sector-erase-active input is high and the suspended input is low. Otherwise it is ignored.
- R10: In read mode, 30h raises a resume pulse while the suspended input is high. It raises an added sector-erase pulse while the erase-window input is high and suspended is low. Otherwise it is ignored.
- R11: Engine status is judged as it stands in the clock cycle in which the write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Active-low chip enable from the host bus |
| bus_we_n | input | 1 | Active-low write enable from the host bus |
| bus_addr | input | 19 | Host byte address |
| bus_data | input | 8 | Host write data |
| se_active | input | 1 | Engine: sector erase pending or running |
| se_window | input | 1 | Engine: sector-add time-out window open |
| se_suspended | input | 1 | Engine: sector erase currently suspended |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| sect_sel | output | 3 | Sector index for the sector erase request |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program data byte |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |

## Verification
Two things can land in the same cycle: the completion of a host write and a change of the engine's status inputs. The bench provokes this by toggling se_active in the same clock phase that releases the strobe of a B0h write. It does so once lowering the input and once raising it. The decision must follow the status present when the synchronized rising edge is evaluated. So the first case must give no suspend pulse and the second must give exactly one.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] UNLOCK_A1 = 11'h555;
  localparam logic [CMD_AW-1:0] UNLOCK_A2 = 11'h2AA;
  localparam logic [7:0] UNLOCK_D1  = 8'hAA;
  localparam logic [7:0] UNLOCK_D2  = 8'h55;
  localparam logic [7:0] CMD_ERSU   = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_PROGSU = 8'hA0;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_ESET, ST_EUNL1, ST_EUNL2, ST_PROG
  } seq_state_t;

  // true when a write hits the expected low address and data
  function automatic logic cycle_hit(input logic [CMD_AW-1:0] a, input logic [7:0] d,
                                     input logic [CMD_AW-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction
endpackage

// File: rtl/fcd_strobe_sync.sv
module fcd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '1;
    else        shreg <= {shreg[LAST-1:0], strobe_n_i};
  end

  assign fall_o = shreg[LAST] & ~shreg[LAST-1];
  assign rise_o = ~shreg[LAST] & shreg[LAST-1];
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              se_active_i,
  input  logic              se_window_i,
  input  logic              se_susp_i,
  output seq_state_t        state_o,
  output logic              chip_o,
  output logic              sect_o,
  output logic [SECT_W-1:0] sect_sel_o,
  output logic              prog_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              susp_o,
  output logic              res_o
);
  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  seq_state_t        state, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_AW-1:0] low_a;
  logic w_chip, w_sect, w_prog, w_susp, w_res;

  assign low_a = addr_q[CMD_AW-1:0];

  always_comb begin
    nxt = ST_IDLE;
    {w_chip, w_sect, w_prog, w_susp, w_res} = '0;
    if (data_i != CMD_RESET) begin
      case (state)
        ST_IDLE: begin
          if (cycle_hit(low_a, data_i, UNLOCK_A1, UNLOCK_D1)) nxt = ST_UNL1;
          else if (data_i == CMD_SUSP) w_susp = se_active_i && !se_susp_i;
          else if (data_i == CMD_SECT) begin
            w_res  = se_susp_i;
            w_sect = se_window_i && !se_susp_i;
          end
        end
        ST_UNL1:  if (cycle_hit(low_a, data_i, UNLOCK_A2, UNLOCK_D2)) nxt = ST_UNL2;
        ST_UNL2: begin
          if (cycle_hit(low_a, data_i, UNLOCK_A1, CMD_PROGSU)) nxt = ST_PROG;
          else if (cycle_hit(low_a, data_i, UNLOCK_A1, CMD_ERSU)) nxt = ST_ESET;
        end
        ST_ESET:  if (cycle_hit(low_a, data_i, UNLOCK_A1, UNLOCK_D1)) nxt = ST_EUNL1;
        ST_EUNL1: if (cycle_hit(low_a, data_i, UNLOCK_A2, UNLOCK_D2)) nxt = ST_EUNL2;
        ST_EUNL2: begin
          w_chip = cycle_hit(low_a, data_i, UNLOCK_A1, CMD_CHIP);
          w_sect = (data_i == CMD_SECT);
        end
        ST_PROG:  w_prog = 1'b1;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      chip_o      <= 1'b0;
      sect_o      <= 1'b0;
      prog_o      <= 1'b0;
      susp_o      <= 1'b0;
      res_o       <= 1'b0;
      sect_sel_o  <= '0;
      prog_addr_o <= '0;
      prog_data_o <= '0;
    end else begin
      chip_o <= 1'b0;
      sect_o <= 1'b0;
      prog_o <= 1'b0;
      susp_o <= 1'b0;
      res_o  <= 1'b0;
      if (fall_i) addr_q <= addr_i;
      if (rise_i) begin
        state  <= nxt;
        chip_o <= w_chip;
        sect_o <= w_sect;
        prog_o <= w_prog;
        susp_o <= w_susp;
        res_o  <= w_res;
        if (w_sect) sect_sel_o <= sector_of(addr_q);
        if (w_prog) begin
          prog_addr_o <= addr_q;
          prog_data_o <= data_i;
        end
      end
    end
  end

  assign state_o = state;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int SECT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              se_active,
  input  logic              se_window,
  input  logic              se_suspended,
  output logic              chip_erase_req,
  output logic              sect_erase_req,
  output logic [SECT_W-1:0] sect_sel,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              suspend_req,
  output logic              resume_req
);
  logic       strobe_n;
  logic       wr_start;
  logic       wr_done;
  seq_state_t seq_state;

  assign strobe_n = bus_ce_n | bus_we_n;

  fcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_n_i (strobe_n),
    .fall_o     (wr_start),
    .rise_o     (wr_done)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_i      (wr_start),
    .rise_i      (wr_done),
    .addr_i      (bus_addr),
    .data_i      (bus_data),
    .se_active_i (se_active),
    .se_window_i (se_window),
    .se_susp_i   (se_suspended),
    .state_o     (seq_state),
    .chip_o      (chip_erase_req),
    .sect_o      (sect_erase_req),
    .sect_sel_o  (sect_sel),
    .prog_o      (prog_req),
    .prog_addr_o (prog_addr),
    .prog_data_o (prog_data),
    .susp_o      (suspend_req),
    .res_o       (resume_req)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_done,
  input logic [7:0] wr_data,
  input seq_state_t seq_state,
  input logic       se_active,
  input logic       se_suspended,
  input logic       chip_erase_req,
  input logic       sect_erase_req,
  input logic       prog_req,
  input logic       suspend_req,
  input logic       resume_req
);
  logic any_req;
  assign any_req = chip_erase_req | sect_erase_req | prog_req | suspend_req | resume_req;

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_erase_req, sect_erase_req, prog_req, suspend_req, resume_req})); // R2
  AST_CHIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_req |=> !chip_erase_req); // R2
  AST_CHIP_AFTER_SIX: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_req |-> $past(seq_state == ST_EUNL2)); // R2
  AST_SECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sect_erase_req |-> $past(seq_state == ST_EUNL2 || seq_state == ST_IDLE)); // R3
  AST_PROG_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(seq_state == ST_PROG)); // R4
  AST_REQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> $past(wr_done)); // R7
  AST_F0_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wr_data == CMD_RESET) |=> (seq_state == ST_IDLE && !any_req)); // R6
  AST_SUSPEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> $past(se_active && !se_suspended)); // R9
  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(se_suspended)); // R10
  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |=> $stable(seq_state)); // R5
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_done        (wr_done),
  .wr_data        (bus_data),
  .seq_state      (seq_state),
  .se_active      (se_active),
  .se_suspended   (se_suspended),
  .chip_erase_req (chip_erase_req),
  .sect_erase_req (sect_erase_req),
  .prog_req       (prog_req),
  .suspend_req    (suspend_req),
  .resume_req     (resume_req)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  data = '0;
  logic        se_active = 1'b0, se_window = 1'b0, se_susp = 1'b0;
  logic        chip_r, sect_r, prog_r, susp_r, res_r;
  logic [2:0]  sect_sel;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data;

  int checks = 0, errors = 0;
  int n_chip = 0, n_sect = 0, n_prog = 0, n_susp = 0, n_res = 0;
  logic [2:0]  last_sect = '0;
  logic [18:0] last_paddr = '0;
  logic [7:0]  last_pdata = '0;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_data(data), .se_active(se_active),
    .se_window(se_window), .se_suspended(se_susp),
    .chip_erase_req(chip_r), .sect_erase_req(sect_r), .sect_sel(sect_sel),
    .prog_req(prog_r), .prog_addr(prog_addr), .prog_data(prog_data),
    .suspend_req(susp_r), .resume_req(res_r)
  );

  always @(negedge clk) begin
    if (chip_r) n_chip++;
    if (sect_r) begin n_sect++; last_sect = sect_sel; end
    if (prog_r) begin n_prog++; last_paddr = prog_addr; last_pdata = prog_data; end
    if (susp_r) n_susp++;
    if (res_r)  n_res++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  function automatic int total();
    return n_chip + n_sect + n_prog + n_susp + n_res;
  endfunction

  // {addr, data, expected: 0 none, 1 chip, 2 sector, 3 program}
  localparam int NV = 26;
  localparam logic [28:0] TBL [NV] = '{
    {19'h00555, 8'hAA, 2'd0}, {19'h002AA, 8'h55, 2'd0}, {19'h00555, 8'h80, 2'd0},
    {19'h00555, 8'hAA, 2'd0}, {19'h002AA, 8'h55, 2'd0}, {19'h00555, 8'h10, 2'd1},
    {19'h70555, 8'hAA, 2'd0}, {19'h002AA, 8'h55, 2'd0}, {19'h00555, 8'h80, 2'd0},
    {19'h00555, 8'hAA, 2'd0}, {19'h002AA, 8'h55, 2'd0}, {19'h61234, 8'h30, 2'd2},
    {19'h00555, 8'hAA, 2'd0}, {19'h002AA, 8'h55, 2'd0}, {19'h00555, 8'hA0, 2'd0},
    {19'h12345, 8'h3C, 2'd3},
    {19'h00555, 8'hAA, 2'd0}, {19'h002AA, 8'h55, 2'd0}, {19'h00555, 8'h80, 2'd0},
    {19'h00555, 8'hAA, 2'd0}, {19'h002AA, 8'h56, 2'd0}, {19'h00555, 8'h10, 2'd0},
    {19'h00555, 8'hAA, 2'd0}, {19'h002AA, 8'h55, 2'd0}, {19'h00555, 8'hF0, 2'd0},
    {19'h00100, 8'h5A, 2'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, p0, s0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({chip_r, sect_r, prog_r, susp_r, res_r} == 5'b0, "R1 reqs during reset",
        {chip_r, sect_r, prog_r, susp_r, res_r}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(total() == 0 && !prog_r, "R1 idle after reset", total(), 0);

    // table walk: R2 chip, R3 sector, R4 program, R5 wrong cycle, R6 F0
    for (int i = 0; i < NV; i++) begin
      logic [18:0] a;
      logic [7:0]  d;
      logic [1:0]  c;
      int before_c, before_s, before_p, before_t;
      a = TBL[i][28:10]; d = TBL[i][9:2]; c = TBL[i][1:0];
      before_c = n_chip; before_s = n_sect; before_p = n_prog; before_t = total();
      wr(a, d);
      case (c)
        2'd1: chk(n_chip == before_c + 1 && total() == before_t + 1, "R2 chip erase",
                  total() - before_t, 1);
        2'd2: begin
          chk(n_sect == before_s + 1 && total() == before_t + 1, "R3 sector erase",
              total() - before_t, 1);
          chk(last_sect == a[18:16], "R3 sector select", last_sect, a[18:16]);
        end
        2'd3: begin
          chk(n_prog == before_p + 1, "R4 program", n_prog - before_p, 1);
          chk(last_paddr == a && last_pdata == d, "R4 program addr/data",
              {last_paddr, last_pdata}, {a, d});
        end
        default: chk(total() == before_t, "R5/R6 no request", total() - before_t, 0);
      endcase
    end

    // R7: address at falling edge, data at rising edge
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'hA0);
    p0 = n_prog;
    @(negedge clk);
    addr = 19'h0ABCD; data = 8'h11; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    addr = 19'h54321; data = 8'hE7;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_prog == p0 + 1, "R7 program issued", n_prog - p0, 1);
    chk(last_paddr == 19'h0ABCD, "R7 address from falling edge", last_paddr, 19'h0ABCD);
    chk(last_pdata == 8'hE7, "R7 data from rising edge", last_pdata, 8'hE7);

    // R8: write enable alone is ignored
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'hA0);
    p0 = n_prog;
    @(negedge clk);
    addr = 19'h00001; data = 8'h77; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_prog == p0, "R8 WE-only pulse ignored", n_prog - p0, 0);
    wr(19'h00002, 8'h99);
    chk(n_prog == p0 + 1 && last_paddr == 19'h00002 && last_pdata == 8'h99,
        "R8 real write after WE-only", last_paddr, 19'h00002);

    // R6: F0 while waiting for program data
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'hA0);
    p0 = n_prog;
    wr(19'h00010, 8'hF0);
    wr(19'h00020, 8'h42);
    chk(n_prog == p0, "R6 F0 cancels program", n_prog - p0, 0);

    // R9: suspend gating
    s0 = n_susp;
    se_active = 1'b1;
    wr(19'h00000, 8'hB0);
    chk(n_susp == s0 + 1, "R9 suspend during sector erase", n_susp - s0, 1);
    se_active = 1'b0;
    wr(19'h00000, 8'hB0);
    chk(n_susp == s0 + 1, "R9 suspend ignored without sector erase", n_susp - s0, 1);
    se_active = 1'b1; se_susp = 1'b1;
    wr(19'h00000, 8'hB0);
    chk(n_susp == s0 + 1, "R9 suspend ignored when suspended", n_susp - s0, 1);

    // R10: resume and added sector
    c0 = n_res;
    wr(19'h00000, 8'h30);
    chk(n_res == c0 + 1, "R10 resume while suspended", n_res - c0, 1);
    se_susp = 1'b0; se_window = 1'b1;
    s0 = n_sect;
    wr(19'h40000, 8'h30);
    chk(n_sect == s0 + 1 && last_sect == 3'd4, "R10 added sector in window", last_sect, 4);
    se_window = 1'b0; se_active = 1'b0;
    c0 = total();
    wr(19'h00000, 8'h30);
    chk(total() == c0, "R10 lone 30h ignored", total() - c0, 0);

    // R11: status change in the same cycle as write completion
    s0 = n_susp;
    se_active = 1'b1;
    @(negedge clk);
    addr = '0; data = 8'hB0; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; se_active = 1'b0;
    repeat (5) @(negedge clk);
    chk(n_susp == s0, "R11 status dropped at completion", n_susp - s0, 0);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; se_active = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_susp == s0 + 1, "R11 status raised at completion", n_susp - s0, 1);
    se_active = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule